// File: doc/BRIEF.md
# Early-Terminating Iterative Multiply-Accumulate Unit

This block is a sequential multiplier that returns the low 32 bits of the product of two 32-bit operands. It handles one 8-bit digit of the multiplier per array cycle. Before the array cycles begin it inspects the multiplier. Once the remaining upper bits are nothing but copies of the sign bit, it stops. Small positive and small negative multipliers therefore finish in fewer cycles than wide ones.

A new operation is launched with a one-cycle start strobe while the unit is idle. The unit then spends one set-up cycle, followed by one to four array cycles. When accumulate is selected it spends one further cycle adding a third operand. Completion is marked by a single-cycle done pulse. Along with the result, the unit supplies condition flags with per-flag write enables and the number of array cycles that were used.

The flag outputs are meant to feed a flag register that is written only where its write enable is set. Negative and zero are written from the result. Carry is written with a value that carries no meaning. Overflow is never written, so it keeps whatever value it had before.

Top module: `early_mac`

## Requirements
- R1: After reset, busy, done, result, flags_we and cycles are all zero.
- R2: For a plain multiply, result equals the low 32 bits of op_a times op_b. This holds whether op_b is read as signed or as unsigned.
- R3: The array-cycle count m is the smallest k in 1..3 for which op_b bits [31:8k] are all zeros or all ones, and 4 otherwise. It is reported on cycles together with done.
- R4: With acc_sel high at start, result equals the low 32 bits of op_a times op_b plus op_c.
- R5: busy is high for exactly 1+m cycles after an accepted start, or 2+m with accumulate. done rises in the cycle right after the last busy cycle.
- R6: done is high for one cycle only. result and cycles stay unchanged until the next accepted start.
- R7: A start pulse while busy is high is ignored and has no effect on the operation in progress.
- R8: If flag_sel was high at start, flags_we is 4'b1110 in the done cycle. flags_we bit 3 enables negative, bit 2 zero, bit 1 carry and bit 0 overflow. flags[3] equals result[31], flags[2] is high exactly when result is zero, and flags[1] has no defined meaning. If flag_sel was low, flags_we stays 0.
- R9: flags_we is zero in every cycle other than the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, accepted only while idle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier; its width of significance sets the cycle count |
| op_c | input | 32 | Accumuland |
| acc_sel | input | 1 | Add op_c to the product |
| flag_sel | input | 1 | Produce flag write enables at completion |
| result | output | 32 | Low 32 bits of the result, held after done |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| flags | output | 4 | {negative, zero, carry, overflow} values |
| flags_we | output | 4 | Per-flag write enables, same bit order as flags |
| cycles | output | 3 | Array cycles used by the last operation |

## Verification
Completion of one operation and acceptance of the next can land in the same cycle. The done pulse, the flag write enables and the result update of the finishing operation coincide with a start that is legal because busy has already dropped. The bench provokes this by raising start in the very cycle in which done is seen. It judges the case by checking both results: the finishing operation's result and flags must be correct in that cycle, and the new operation must then show its own busy length and result. A start raised in the middle of a busy period is checked separately: it must neither change the running result nor lengthen the operation.

// File: rtl/early_mac.sv
module early_mac #(
  parameter int W = 32,
  parameter int D = 8,
  localparam int ND = W / D,
  localparam int CW = $clog2(ND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  op_c,
  input  logic          acc_sel,
  input  logic          flag_sel,
  output logic [W-1:0]  result,
  output logic          done,
  output logic          busy,
  output logic [3:0]    flags,
  output logic [3:0]    flags_we,
  output logic [CW-1:0] cycles
);

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_ARR, S_ACC} st_t;

  st_t          st;
  logic [W-1:0] mc_q, mp_q, acc_q, add_q;
  logic         accen_q, fen_q, neg_q;
  logic [CW-1:0] m_q, k_q;
  logic [CW-1:0] m_new;

  always_comb begin
    m_new = CW'(ND);
    for (int k = ND - 1; k >= 1; k--)
      if (((op_b ^ {W{op_b[W-1]}}) >> (D * k)) == '0) m_new = CW'(k);
  end

  logic         last;
  logic [W-1:0] term, corr, acc_d, fin_val;
  logic         fin;

  assign last    = (k_q + 1'b1) == m_q;
  assign term    = mc_q * W'(mp_q[D-1:0]);
  assign corr    = (last && neg_q) ? (mc_q << D) : '0;
  assign acc_d   = acc_q + term - corr;
  assign fin_val = (st == S_ACC) ? (acc_q + add_q) : acc_d;
  assign fin     = (st == S_ACC) || (st == S_ARR && last && !accen_q);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mc_q     <= '0;
      mp_q     <= '0;
      acc_q    <= '0;
      add_q    <= '0;
      accen_q  <= 1'b0;
      fen_q    <= 1'b0;
      neg_q    <= 1'b0;
      m_q      <= '0;
      k_q      <= '0;
      result   <= '0;
      done     <= 1'b0;
      flags    <= '0;
      flags_we <= '0;
      cycles   <= '0;
    end else begin
      done     <= 1'b0;
      flags_we <= '0;
      case (st)
        S_IDLE: if (start) begin
          mc_q    <= op_a;
          mp_q    <= op_b;
          add_q   <= op_c;
          accen_q <= acc_sel;
          fen_q   <= flag_sel;
          neg_q   <= op_b[W-1];
          m_q     <= m_new;
          k_q     <= '0;
          acc_q   <= '0;
          st      <= S_SEQ;
        end
        S_SEQ: st <= S_ARR;
        S_ARR: begin
          acc_q <= acc_d;
          mc_q  <= mc_q << D;
          mp_q  <= mp_q >> D;
          k_q   <= k_q + 1'b1;
          if (last) st <= accen_q ? S_ACC : S_IDLE;
        end
        S_ACC: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (fin) begin
        result   <= fin_val;
        done     <= 1'b1;
        cycles   <= m_q;
        flags    <= {fin_val[W-1], fin_val == '0, 1'b0, 1'b0};
        flags_we <= fen_q ? 4'b1110 : 4'b0000;
      end
    end
  end

endmodule

module early_mac_chk #(
  parameter int W = 32,
  parameter int D = 8,
  localparam int ND = W / D,
  localparam int CW = $clog2(ND + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  result,
  input logic [3:0]    flags,
  input logic [3:0]    flags_we,
  input logic [CW-1:0] cycles
);

  int unsigned bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= 0;
    else        bcnt <= busy ? bcnt + 1 : 0;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> bcnt <= ND + 1); // R5
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(result) && $stable(cycles))); // R6
  AST_FLAG_N: assert property (@(posedge clk) disable iff (!rst_n) flags_we[3] |-> flags[3] == result[W-1]); // R8
  AST_FLAG_Z: assert property (@(posedge clk) disable iff (!rst_n) flags_we[2] |-> flags[2] == (result == '0)); // R8
  AST_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n) (|flags_we) |-> done); // R9
  AST_CYCLES_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cycles >= 1 && cycles <= ND)); // R3

endmodule

bind early_mac early_mac_chk #(.W(W), .D(D)) u_chk (.*);

// File: tb/early_mac_tb.sv
module early_mac_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0;
  logic        acc_sel = 1'b0, flag_sel = 1'b0;
  logic [31:0] result;
  logic        done, busy;
  logic [3:0]  flags, flags_we;
  logic [2:0]  cycles;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  early_mac u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .acc_sel(acc_sel), .flag_sel(flag_sel), .result(result),
    .done(done), .busy(busy), .flags(flags), .flags_we(flags_we), .cycles(cycles)
  );

  localparam int NV = 12;
  localparam logic [31:0] TA [NV] = '{32'd7, 32'h12345678, 32'h00001000, 32'hDEADBEEF,
    32'h89ABCDEF, 32'd3, 32'hCAFEBABE, 32'h11111111, 32'd5, 32'hFFFFFFFF, 32'd0, 32'd1};
  localparam logic [31:0] TB [NV] = '{32'd5, 32'hFFFFFFFD, 32'hFFFFFF05, 32'h00001234,
    32'hFFFF8001, 32'h00ABCDEF, 32'h12345678, 32'h80000000, 32'd6, 32'h00FF0000,
    32'h12345678, 32'hFFFFFFFF};
  localparam logic [31:0] TC [NV] = '{32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
    32'd0, 32'd0, 32'd100, 32'd1, 32'd9, 32'd1};
  localparam logic [NV-1:0] TACC = 12'b1011_0000_0000;
  localparam logic [NV-1:0] TSF  = 12'b1101_0101_0110;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int exp_m(input logic [31:0] b);
    for (int k = 1; k < 4; k++) begin
      logic [31:0] hi = b >> (8 * k);
      logic [31:0] ones = 32'hFFFFFFFF >> (8 * k);
      if (hi == 0 || hi == ones) return k;
    end
    return 4;
  endfunction

  task automatic issue(input logic [31:0] a, b, c, input logic acc, sf);
    start = 1'b1; op_a = a; op_b = b; op_c = c; acc_sel = acc; flag_sel = sf;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(output int n, output int we_bad);
    int g = 0;
    n = 0; we_bad = 0;
    while (!done && g < 64) begin
      if (busy) n++;
      if (flags_we != 0) we_bad++;
      @(negedge clk);
      g++;
    end
  endtask

  task automatic finish_op(input logic [31:0] a, b, c, input logic acc, sf, input int skipped);
    int n, wb;
    logic [31:0] e = a * b + (acc ? c : 32'd0);
    int m = exp_m(b);
    collect(n, wb);
    chk(done === 1'b1, "R5 done seen", {31'd0, done}, 32'd1);
    chk(result === e, acc ? "R4 mac result" : "R2 product", result, e);
    chk(cycles === 3'(m), "R3 array cycles", {29'd0, cycles}, m);
    chk(n + skipped == 1 + m + int'(acc), "R5 busy length", n + skipped, 1 + m + int'(acc));
    chk(wb == 0, "R9 we outside done", wb, 0);
    if (sf) begin
      chk(flags_we === 4'b1110, "R8 flag enables", {28'd0, flags_we}, 32'hE);
      chk(flags[3] === e[31] && flags[2] === (e == 0), "R8 N/Z values",
          {28'd0, flags}, {28'd0, e[31], e == 0, 2'b00});
    end else
      chk(flags_we === 4'b0000, "R8 no flag write", {28'd0, flags_we}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0, "R1 busy/done", {30'd0, busy, done}, 0);
    chk(result === 0 && cycles === 0 && flags_we === 0, "R1 outputs",
        result | {29'd0, cycles} | {28'd0, flags_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(TA[i], TB[i], TC[i], TACC[i], TSF[i]);
      finish_op(TA[i], TB[i], TC[i], TACC[i], TSF[i], 0);
      @(negedge clk);
    end

    // R6: held result, single-cycle done
    begin
      logic [31:0] keep = result;
      chk(done === 1'b0, "R6 done one cycle", {31'd0, done}, 0);
      repeat (4) @(negedge clk);
      chk(result === keep && cycles === 3'd1, "R6 result held", result, keep);
    end

    // R7: start while busy is ignored
    issue(32'h0BADF00D, 32'h7EDCBA98, 32'd0, 1'b0, 1'b0);
    start = 1'b1; op_a = 32'h1; op_b = 32'h2; op_c = 32'h3; acc_sel = 1'b1; flag_sel = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_op(32'h0BADF00D, 32'h7EDCBA98, 32'd0, 1'b0, 1'b0, 1);

    // back-to-back: start in the done cycle
    issue(32'd11, 32'hFFFFFFF0, 32'd0, 1'b1, 1'b1);
    finish_op(32'd11, 32'hFFFFFFF0, 32'd0, 1'b1, 1'b1, 0);
    issue(32'h00010001, 32'h00C00000, 32'h5, 1'b1, 1'b1);
    chk(busy === 1'b1 && done === 1'b0, "R5 back-to-back accepted", {30'd0, busy, done}, 32'h2);
    finish_op(32'h00010001, 32'h00C00000, 32'h5, 1'b1, 1'b1, 0);
    @(negedge clk);

    // R1: reset mid-operation clears outputs
    issue(32'h5, 32'h40000000, 32'h0, 1'b0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && result === 0, "R1 reset mid-op", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule